// File: doc/BRIEF.md
# Dual-Buffer Instruction Prefetch Unit

This unit sits between an instruction fetch stage and an instruction cache. It holds two fetch buffers, each covering one aligned block of `FETCH_BYTES` bytes. When a fetch address arrives, the unit works out which buffer already covers it, or picks one. It starts a cache load for that buffer if needed. It aims the other buffer at the next sequential block, and holds the fetch stage until the chosen buffer has its data.

Every cache load carries a number from one shared counter and the index of the buffer it fills. The cache returns that number in its response, and the unit matches each response to a buffer by this number. A branch penalty can be posted by the pipeline; the next fetch then spends that many cycles in a penalty stall before it waits on the buffer. Two saturating counters report how many cycles were spent waiting for fills and how many were spent in penalty stalls. When both the cache-enable and the cycle-count inputs are low, the unit does nothing, and each fetch completes at once.

Top module: `ifetch_prebuf`

## Requirements
- R1: The fetch address is aligned down to a multiple of `FETCH_BYTES`, which is 8 or 16. Load requests carry aligned addresses only.
- R2: If a valid buffer holds the aligned address, that buffer becomes current. If no buffer holds it, buffer 0 becomes current. `fetch_buf` reports the current buffer (0 or 1) in the cycle `fetch_done` is high.
- R3: If the current buffer misses, it is retargeted to the aligned address, marked pending, and a load request is sent for it with `req_buf` equal to its index.
- R4: The other buffer (index current XOR 1) must hold the aligned address plus `FETCH_BYTES`. If it does not, it is retargeted to that address and a second request follows.
- R5: All request numbers come from one counter. The counter starts at 0x80000000 after reset and goes up by one for each request. Requests reach the port one per cycle, the current buffer's request first.
- R6: While the current buffer is pending, `fetch_done` stays low and `fetch_stall` stays high. `fetch_done` goes high in the first cycle after the matching response is registered. A fetch that hits a filled buffer completes one cycle after it is accepted.
- R7: A response clears the pending state only of a buffer whose stored number equals `rsp_num`. A response whose number matches no buffer has no effect.
- R8: A penalty of N cycles posted on `penalty_set` is spent by the next accepted fetch as N stall cycles before the buffer wait, and is then cleared. Later fetches pay no penalty.
- R9: When both `cache_en` and `count_en` are low, a fetch completes in the cycle it is presented. No request is issued, no buffer changes, and neither counter moves.
- R10: `stall_count` counts cycles spent waiting on a pending current buffer. `penalty_count` counts penalty stall cycles. Both are `CNT_W` bits wide and saturate at all ones.
- R11: After reset both counters are zero, no request is valid, and both buffers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Instruction cache enabled |
| count_en | input | 1 | Cycle accounting enabled |
| fetch_valid | input | 1 | Fetch address presented; held until `fetch_done` |
| fetch_addr | input | 32 | Byte address of the fetch |
| fetch_stall | output | 1 | Fetch presented but not yet complete |
| fetch_done | output | 1 | Fetch complete this cycle |
| fetch_buf | output | 1 | Buffer that serves the completed fetch |
| penalty_set | input | 1 | Post a branch penalty |
| penalty_len | input | PEN_W | Penalty length in cycles |
| req_valid | output | 1 | Load request to the cache |
| req_buf | output | 1 | Buffer index of the request |
| req_addr | output | 32 | Aligned block address of the request |
| req_num | output | 32 | Request number |
| rsp_valid | input | 1 | Cache response |
| rsp_num | input | 32 | Request number being answered |
| stall_count | output | CNT_W | Saturating fill-wait cycle count |
| penalty_count | output | CNT_W | Saturating penalty cycle count |

## Verification
The bench builds the unit with `FETCH_BYTES` = 16, `CNT_W` = 16 and `PEN_W` = 4. With 16-byte blocks, addresses such as 0x21F and 0x2FF must align down, and a sequence of fetches can move the current role from one buffer to the other and back. The 16-bit counter width lets a single long fill drive `stall_count` to saturation well within the cycle budget. The 4-bit penalty field allows a multi-cycle penalty whose length can be measured exactly from fetch latency.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

    parameter int unsigned ADDR_W    = 32;
    parameter int unsigned NUM_W     = 32;
    parameter logic [NUM_W-1:0] NUM_RESET = 32'h8000_0000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEN  = 2'd1,
        ST_WAIT = 2'd2
    } ctrl_state_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [NUM_W-1:0]  num;
        logic              pend;
    } fbuf_t;

    typedef struct packed {
        logic              valid;
        logic              idx;
        logic [ADDR_W-1:0] addr;
        logic [NUM_W-1:0]  num;
    } ldreq_t;

    function automatic logic [ADDR_W-1:0] align_down(
        input logic [ADDR_W-1:0] a,
        input int unsigned       bytes
    );
        return a & ~(ADDR_W'(bytes) - ADDR_W'(1));
    endfunction

endpackage

// File: rtl/ifp_match.sv
module ifp_match
    import ifp_pkg::*;
#(
    parameter int unsigned FETCH_BYTES = 16
) (
    input  fbuf_t [1:0]       bufs,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] aligned,
    output logic [ADDR_W-1:0] next_addr,
    output logic              cur_idx,
    output logic              cur_miss,
    output logic              pre_miss
);
    localparam int unsigned STEP = (FETCH_BYTES == 8) ? 8 : 16;

    logic [1:0] hit;
    logic       pre_idx;

    assign aligned   = align_down(fetch_addr, STEP);
    assign next_addr = aligned + ADDR_W'(STEP);

    for (genvar i = 0; i < 2; i++) begin : g_hit
        assign hit[i] = bufs[i].valid && (bufs[i].addr == aligned);
    end

    always_comb begin
        cur_idx  = hit[1] && !hit[0];
        cur_miss = !(hit[0] || hit[1]);
        pre_idx  = ~cur_idx;
        pre_miss = !(bufs[pre_idx].valid && (bufs[pre_idx].addr == next_addr));
    end
endmodule

// File: rtl/ifp_bufs.sv
module ifp_bufs
    import ifp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              cur_idx,
    input  logic              cur_miss,
    input  logic              pre_miss,
    input  logic [ADDR_W-1:0] aligned,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [NUM_W-1:0]  base_num,
    input  logic              rsp_valid,
    input  logic [NUM_W-1:0]  rsp_num,
    output fbuf_t [1:0]       bufs
);
    for (genvar i = 0; i < 2; i++) begin : g_buf
        logic              is_cur;
        logic              retarget;
        logic [ADDR_W-1:0] new_addr;
        logic [NUM_W-1:0]  new_num;

        always_comb begin
            is_cur   = (cur_idx == 1'(i));
            retarget = load && (is_cur ? cur_miss : pre_miss);
            new_addr = is_cur ? aligned : next_addr;
            new_num  = is_cur ? base_num
                              : base_num + {{(NUM_W-1){1'b0}}, cur_miss};
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                bufs[i] <= '0;
            end else if (retarget) begin
                bufs[i].valid <= 1'b1;
                bufs[i].addr  <= new_addr;
                bufs[i].num   <= new_num;
                bufs[i].pend  <= 1'b1;
            end else if (rsp_valid && bufs[i].pend && (bufs[i].num == rsp_num)) begin
                bufs[i].pend  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ifp_reqq.sv
module ifp_reqq
    import ifp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              cur_idx,
    input  logic              cur_miss,
    input  logic              pre_miss,
    input  logic [ADDR_W-1:0] aligned,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [NUM_W-1:0]  base_num,
    output ldreq_t            head
);
    ldreq_t slot0, slot1;
    ldreq_t cur_r, pre_r;
    logic [NUM_W-1:0] inc;

    always_comb begin
        cur_r.valid = 1'b1;
        cur_r.idx   = cur_idx;
        cur_r.addr  = aligned;
        cur_r.num   = base_num;
        pre_r.valid = 1'b1;
        pre_r.idx   = ~cur_idx;
        pre_r.addr  = next_addr;
        pre_r.num   = base_num + {{(NUM_W-1){1'b0}}, cur_miss};
        inc         = {{(NUM_W-1){1'b0}}, cur_miss} + {{(NUM_W-1){1'b0}}, pre_miss};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot0    <= '0;
            slot1    <= '0;
            base_num <= NUM_RESET;
        end else if (load) begin
            base_num <= base_num + inc;
            if (cur_miss) begin
                slot0 <= cur_r;
                slot1 <= pre_miss ? pre_r : '0;
            end else begin
                slot0 <= pre_miss ? pre_r : '0;
                slot1 <= '0;
            end
        end else begin
            slot0 <= slot1;
            slot1 <= '0;
        end
    end

    assign head = slot0;
endmodule

// File: rtl/ifp_ctrl.sv
module ifp_ctrl
    import ifp_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic             suppress,
    input  logic             cur_idx,
    input  logic             cur_pend,
    input  logic             penalty_set,
    input  logic [PEN_W-1:0] penalty_len,
    output logic             load,
    output logic             fetch_done,
    output logic             fetch_buf,
    output logic             cur_q,
    output logic [CNT_W-1:0] stall_count,
    output logic [CNT_W-1:0] penalty_count
);
    ctrl_state_t      state;
    logic             pen_pending;
    logic [PEN_W-1:0] pen_len_q;
    logic [PEN_W-1:0] pen_left;
    logic             pen_due;

    assign pen_due = pen_pending && (pen_len_q != '0);

    always_comb begin
        load       = (state == ST_IDLE) && fetch_valid && !suppress;
        fetch_done = ((state == ST_IDLE) && fetch_valid && suppress)
                  || ((state == ST_WAIT) && !cur_pend);
        fetch_buf  = (state == ST_IDLE) ? cur_idx : cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cur_q         <= 1'b0;
            pen_pending   <= 1'b0;
            pen_len_q     <= '0;
            pen_left      <= '0;
            stall_count   <= '0;
            penalty_count <= '0;
        end else begin
            if (penalty_set) begin
                pen_pending <= 1'b1;
                pen_len_q   <= penalty_len;
            end else if (load) begin
                pen_pending <= 1'b0;
            end

            unique case (state)
                ST_IDLE: begin
                    if (load) begin
                        cur_q <= cur_idx;
                        if (pen_due) begin
                            pen_left <= pen_len_q;
                            state    <= ST_PEN;
                        end else begin
                            state    <= ST_WAIT;
                        end
                    end
                end
                ST_PEN: begin
                    if (penalty_count != '1)
                        penalty_count <= penalty_count + 1'b1;
                    if (pen_left == PEN_W'(1))
                        state <= ST_WAIT;
                    pen_left <= pen_left - 1'b1;
                end
                ST_WAIT: begin
                    if (cur_pend) begin
                        if (stall_count != '1)
                            stall_count <= stall_count + 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ifetch_prebuf.sv
module ifetch_prebuf
    import ifp_pkg::*;
#(
    parameter int unsigned FETCH_BYTES = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned PEN_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic              count_en,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    output logic              fetch_stall,
    output logic              fetch_done,
    output logic              fetch_buf,
    input  logic              penalty_set,
    input  logic [PEN_W-1:0]  penalty_len,
    output logic              req_valid,
    output logic              req_buf,
    output logic [31:0]       req_addr,
    output logic [31:0]       req_num,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_num,
    output logic [CNT_W-1:0]  stall_count,
    output logic [CNT_W-1:0]  penalty_count
);
    fbuf_t [1:0]       bufs;
    ldreq_t            head;
    logic [ADDR_W-1:0] aligned, next_addr;
    logic [NUM_W-1:0]  base_num;
    logic              cur_idx, cur_miss, pre_miss;
    logic              load, cur_q, cur_pend, suppress;

    assign suppress = !cache_en && !count_en;
    assign cur_pend = bufs[cur_q].pend;

    ifp_match #(.FETCH_BYTES(FETCH_BYTES)) u_match (
        .bufs       (bufs),
        .fetch_addr (fetch_addr),
        .aligned    (aligned),
        .next_addr  (next_addr),
        .cur_idx    (cur_idx),
        .cur_miss   (cur_miss),
        .pre_miss   (pre_miss)
    );

    ifp_bufs u_bufs (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .cur_idx   (cur_idx),
        .cur_miss  (cur_miss),
        .pre_miss  (pre_miss),
        .aligned   (aligned),
        .next_addr (next_addr),
        .base_num  (base_num),
        .rsp_valid (rsp_valid),
        .rsp_num   (rsp_num),
        .bufs      (bufs)
    );

    ifp_reqq u_reqq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .cur_idx   (cur_idx),
        .cur_miss  (cur_miss),
        .pre_miss  (pre_miss),
        .aligned   (aligned),
        .next_addr (next_addr),
        .base_num  (base_num),
        .head      (head)
    );

    ifp_ctrl #(.CNT_W(CNT_W), .PEN_W(PEN_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .fetch_valid   (fetch_valid),
        .suppress      (suppress),
        .cur_idx       (cur_idx),
        .cur_pend      (cur_pend),
        .penalty_set   (penalty_set),
        .penalty_len   (penalty_len),
        .load          (load),
        .fetch_done    (fetch_done),
        .fetch_buf     (fetch_buf),
        .cur_q         (cur_q),
        .stall_count   (stall_count),
        .penalty_count (penalty_count)
    );

    assign fetch_stall = fetch_valid && !fetch_done;
    assign req_valid   = head.valid;
    assign req_buf     = head.idx;
    assign req_addr    = head.addr;
    assign req_num     = head.num;
endmodule

// File: rtl/ifp_checker.sv
module ifp_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_valid,
    input logic             fetch_done,
    input logic             req_valid,
    input logic [31:0]      req_num,
    input logic [CNT_W-1:0] stall_count,
    input logic [CNT_W-1:0] penalty_count
);
    logic        have_last;
    logic [31:0] last_num;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_last <= 1'b0;
            last_num  <= '0;
        end else if (req_valid) begin
            have_last <= 1'b1;
            last_num  <= req_num;
        end
    end

    assert_done_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
        fetch_done |-> fetch_valid);

    assert_num_sequence_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && have_last) |-> (req_num == last_num + 32'd1));

    assert_stall_no_decrease_R10: assert property (@(posedge clk) disable iff (rst)
        (stall_count != '1) |=> (stall_count >= $past(stall_count)));

    assert_stall_saturates_R10: assert property (@(posedge clk) disable iff (rst)
        (stall_count == '1) |=> (stall_count == '1));

    assert_penalty_no_decrease_R10: assert property (@(posedge clk) disable iff (rst)
        (penalty_count != '1) |=> (penalty_count >= $past(penalty_count)));

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (stall_count == '0 && penalty_count == '0 && !req_valid));
endmodule

bind ifetch_prebuf ifp_checker #(.CNT_W(CNT_W)) u_ifp_checker (
    .clk           (clk),
    .rst           (rst),
    .fetch_valid   (fetch_valid),
    .fetch_done    (fetch_done),
    .req_valid     (req_valid),
    .req_num       (req_num),
    .stall_count   (stall_count),
    .penalty_count (penalty_count)
);

// File: tb/test_ifetch_prebuf.sv
`timescale 1ns/1ps
module test_ifetch_prebuf;
    localparam int CNT_W = 16;
    localparam int PEN_W = 4;
    localparam int NV    = 8;

    localparam logic [31:0] VA [NV] = '{32'h100, 32'h114, 32'h10C, 32'h108,
                                        32'h200, 32'h21F, 32'h220, 32'h2FF};
    localparam int VL [NV] = '{3, 2, 5, 1, 0, 4, 2, 3};
    localparam logic [1:0] VE [NV] = '{2'b10, 2'b01, 2'b11, 2'b10,
                                       2'b01, 2'b11, 2'b10, 2'b01};
    localparam int VC [NV] = '{0, 1, 0, 0, 0, 1, 0, 0};
    localparam int VN [NV] = '{2, 1, 1, 0, 2, 1, 1, 2};
    localparam int VB [NV] = '{0, 0, 0, 0, 0, 0, 1, 0};
    localparam logic [31:0] VR [NV] = '{32'h100, 32'h120, 32'h100, 32'h0,
                                        32'h200, 32'h220, 32'h230, 32'h2F0};
    localparam int VW [NV] = '{4, 0, 6, 0, 1, 0, 0, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cache_en = 1'b1, count_en = 1'b1;
    logic fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic fetch_stall, fetch_done, fetch_buf;
    logic penalty_set = 1'b0;
    logic [PEN_W-1:0] penalty_len = '0;
    logic req_valid, req_buf;
    logic [31:0] req_addr, req_num;
    logic rsp_valid;
    logic [31:0] rsp_num;
    logic [CNT_W-1:0] stall_count, penalty_count;

    logic a_rsp_v = 1'b0, m_rsp_v = 1'b0;
    logic [31:0] a_rsp_num = '0, m_rsp_num = '0;
    assign rsp_valid = a_rsp_v | m_rsp_v;
    assign rsp_num   = m_rsp_v ? m_rsp_num : a_rsp_num;

    always #4 clk = ~clk;

    ifetch_prebuf #(.FETCH_BYTES(16), .CNT_W(CNT_W), .PEN_W(PEN_W)) i_ifetch_prebuf (
        .clk(clk), .rst(rst), .cache_en(cache_en), .count_en(count_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_stall(fetch_stall), .fetch_done(fetch_done), .fetch_buf(fetch_buf),
        .penalty_set(penalty_set), .penalty_len(penalty_len),
        .req_valid(req_valid), .req_buf(req_buf), .req_addr(req_addr), .req_num(req_num),
        .rsp_valid(rsp_valid), .rsp_num(rsp_num),
        .stall_count(stall_count), .penalty_count(penalty_count)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done_run = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Cache responder and request monitor
    bit          resp_auto = 1;
    int          lat_cur   = 0;
    int          nreq_seen = 0;
    logic        first_buf;
    logic [31:0] first_addr, first_num;
    logic [31:0] exp_num = 32'h8000_0000;
    bit          pq_v   [8];
    logic [31:0] pq_num [8];
    int          pq_due [8];

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst && req_valid) begin
            check(req_num == exp_num, "R5 request number", req_num, exp_num);
            exp_num++;
            nreq_seen++;
            if (nreq_seen == 1) begin
                first_buf  = req_buf;
                first_addr = req_addr;
                first_num  = req_num;
            end
            if (resp_auto) begin
                for (int k = 0; k < 8; k++) begin
                    if (!pq_v[k]) begin
                        pq_v[k] = 1; pq_num[k] = req_num; pq_due[k] = cyc + lat_cur;
                        break;
                    end
                end
            end
        end
        a_rsp_v = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (pq_v[k] && pq_due[k] <= cyc && !a_rsp_v) begin
                a_rsp_v = 1'b1; a_rsp_num = pq_num[k]; pq_v[k] = 0;
            end
        end
    end

    task automatic fetch(input logic [31:0] a, input int lat, output int n, output logic b);
        fetch_valid = 1'b1; fetch_addr = a; lat_cur = lat; n = 0;
        #1;
        while (!fetch_done && n < 150000) begin
            @(negedge clk); #1; n++;
        end
        b = fetch_buf;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        logic b;
        logic [CNT_W-1:0] s0, p0;
        logic [31:0] cur_num, pre_num;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R11 reset state
        check(stall_count == 0, "R11 stall_count", 32'(stall_count), 0);
        check(penalty_count == 0, "R11 penalty_count", 32'(penalty_count), 0);
        check(!req_valid, "R11 req_valid", 32'(req_valid), 0);
        check(!fetch_done && !fetch_stall, "R11 fetch outputs", 32'({fetch_done, fetch_stall}), 0);
        @(negedge clk);

        // Vector table: R1 R2 R3 R4 R6
        for (int v = 0; v < NV; v++) begin
            {cache_en, count_en} = VE[v];
            nreq_seen = 0;
            s0 = stall_count;
            fetch(VA[v], VL[v], n, b);
            settle();
            check(b == 1'(VC[v]), "R2 current buffer", 32'(b), 32'(VC[v]));
            check(nreq_seen == VN[v], "R3/R4 request count", 32'(nreq_seen), 32'(VN[v]));
            if (VN[v] > 0) begin
                check(first_buf == 1'(VB[v]), "R3 request buffer", 32'(first_buf), 32'(VB[v]));
                check(first_addr == VR[v], "R1 aligned request address", first_addr, VR[v]);
            end
            check(32'(stall_count - s0) == 32'(VW[v]), "R6 wait cycles",
                  32'(stall_count - s0), 32'(VW[v]));
        end

        // R8 branch penalty of 3 cycles on a hit
        cache_en = 1'b1; count_en = 1'b1;
        penalty_set = 1'b1; penalty_len = 4'd3;
        @(negedge clk);
        penalty_set = 1'b0;
        p0 = penalty_count; s0 = stall_count; nreq_seen = 0;
        fetch(32'h2F4, 0, n, b);
        check(32'(penalty_count - p0) == 3, "R8 penalty cycles", 32'(penalty_count - p0), 3);
        check(n == 4, "R8 fetch latency with penalty", 32'(n), 4);
        settle();
        p0 = penalty_count;
        fetch(32'h2F0, 0, n, b);
        check(penalty_count == p0, "R8 penalty cleared", 32'(penalty_count), 32'(p0));
        check(n == 1, "R6 hit latency", 32'(n), 1);
        settle();

        // R9 suppression
        cache_en = 1'b0; count_en = 1'b0;
        nreq_seen = 0; s0 = stall_count; p0 = penalty_count;
        fetch(32'h800, 0, n, b);
        settle();
        check(n == 0, "R9 immediate completion", 32'(n), 0);
        check(nreq_seen == 0, "R9 no requests", 32'(nreq_seen), 0);
        check(stall_count == s0 && penalty_count == p0, "R9 counters frozen",
              32'(stall_count), 32'(s0));
        cache_en = 1'b1;
        fetch(32'h2F8, 0, n, b);
        settle();
        check(nreq_seen == 0 && b == 1'b0, "R9 buffers untouched", 32'(nreq_seen), 0);

        // R7 stale responses ignored
        resp_auto = 0; nreq_seen = 0;
        fetch_valid = 1'b1; fetch_addr = 32'h400;
        repeat (4) @(negedge clk);
        cur_num = first_num;
        pre_num = first_num + 1;
        m_rsp_v = 1'b1; m_rsp_num = cur_num + 32'd7;
        @(negedge clk);
        m_rsp_num = pre_num;
        @(negedge clk);
        m_rsp_v = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!fetch_done && fetch_stall, "R7 stale response ignored", 32'(fetch_done), 0);
        @(negedge clk);
        m_rsp_v = 1'b1; m_rsp_num = cur_num;
        @(negedge clk);
        m_rsp_v = 1'b0;
        #1;
        check(fetch_done && fetch_buf == 1'b0, "R7 matching response completes",
              32'(fetch_done), 1);
        @(negedge clk);
        fetch_valid = 1'b0;
        settle();

        // R10 saturation
        nreq_seen = 0;
        fetch_valid = 1'b1; fetch_addr = 32'h600;
        repeat (66000) @(negedge clk);
        check(stall_count == '1, "R10 stall_count saturates", 32'(stall_count), 32'hFFFF);
        m_rsp_v = 1'b1; m_rsp_num = first_num;
        @(negedge clk);
        m_rsp_v = 1'b0;
        #1;
        check(fetch_done, "R6 completes after fill", 32'(fetch_done), 1);
        @(negedge clk);
        fetch_valid = 1'b0;
        #1;
        check(stall_count == '1, "R10 stays saturated", 32'(stall_count), 32'hFFFF);
        finish_run();
    end
endmodule